// File: doc/BRIEF.md
# Reversible Coil Servo Drive with Quadrature Position Tracking

This block commands the four switch enables of an H-bridge that turns a reversible motor on a motorised variable inductor. Two request inputs ask for travel toward the lower or the higher end of the range. Two end-stop inputs stop travel in their own direction and are reported back as status. When no usable request is present, both motor terminals are pulled to ground, so the motor is braked rather than left to coast. A dead cycle with all four switches open separates any drive interval from whatever came before and after it.

A two-phase shaft encoder turns with the inductor. Both phases pass through a synchroniser. Every rising and falling edge of either phase is merged into a single motion event, and each event moves a signed position count one step up or down. The phase order sets the direction of the step. If both phases change within the same sample, that sample cannot be decoded: a sticky error flag is raised and the count is left as it was.

Top module: `coil_servo_drive`

## Requirements
- R1: While reset is held and right after it, the bridge brakes the motor: loSideA=1, loSideB=1, hiSideA=0, hiSideB=0. The position is 0, and motionPulse and stepError are 0.
- R2: Steady drive toward minimum gives exactly hiSideA=1 and loSideB=1. Steady drive toward maximum gives exactly hiSideB=1 and loSideA=1. No leg ever has its high and low switch on together.
- R3: If reqToMin and reqToMax are both high, this counts as no request, and the bridge ends up braking.
- R4: When no request is effective, the bridge settles in the brake pattern (both low sides on) at most two clock edges later.
- R5: A request sampled at a clock edge while braking produces one cycle with all four enables low, and drive begins at the next edge. Dropping a drive also passes through one such all-off cycle before braking resumes.
- R6: limMin=1 forces hiSideA and loSideB low in the same cycle, with no clock edge needed. At the next edge it also stops the drive toward minimum. limMax does the same for hiSideB and loSideA. atMin follows limMin and atMax follows limMax.
- R7: An encoder change reaches position and motionPulse at the third rising clock edge after it is applied, because of the two synchroniser stages and one output register.
- R8: Phase sequence {encA,encB} = 00,10,11,01,00 (encA leading) adds one per edge. The reverse sequence subtracts one per edge. The count wraps in two's complement, so one step below zero gives all ones.
- R9: Each decoded edge of either phase gives a motionPulse high for exactly one cycle. There is no pulse in any cycle with no decoded edge.
- R10: A sample in which both synchronised phases change at once sets stepError. stepError stays set until reset. That sample neither moves the position nor pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqToMin | input | 1 | Request travel toward minimum inductance |
| reqToMax | input | 1 | Request travel toward maximum inductance |
| limMin | input | 1 | End stop reached at minimum |
| limMax | input | 1 | End stop reached at maximum |
| encA | input | 1 | Encoder phase A, asynchronous |
| encB | input | 1 | Encoder phase B, asynchronous |
| hiSideA | output | 1 | High-side switch, motor terminal A |
| loSideA | output | 1 | Low-side switch, motor terminal A |
| hiSideB | output | 1 | High-side switch, motor terminal B |
| loSideB | output | 1 | Low-side switch, motor terminal B |
| atMin | output | 1 | Status: at minimum end stop |
| atMax | output | 1 | Status: at maximum end stop |
| motionPulse | output | 1 | One-cycle pulse per decoded encoder edge |
| stepError | output | 1 | Sticky flag for an undecodable double phase change |
| position | output | POS_W | Signed encoder position count |

## Verification
The hardest cases to reach are an end stop that rises in the middle of a drive cycle and a request that flips direction during the dead cycle. Random stimulus seldom lines either of these up with the state machine. The stimulus therefore raises the limit between clock edges while a drive is running and checks the enables before the next edge. Long random stretches hold requests for several cycles and then change them, so reversals land in every state. The double phase change cannot occur in a legal quadrature walk, so a directed jump of two phase positions produces it. That case is left until the end of the run because its flag is sticky.

// File: rtl/coil_servo_pkg.sv
package coil_servo_pkg;

  typedef enum logic [1:0] {
    DRV_BRAKE = 2'd0,
    DRV_DEAD  = 2'd1,
    DRV_TOMIN = 2'd2,
    DRV_TOMAX = 2'd3
  } drv_state_e;

  // Four switch enables of the H-bridge
  typedef struct packed {
    logic hiA;
    logic loA;
    logic hiB;
    logic loB;
  } bridge_t;

  // Strobes from the edge decoder to the position counter
  typedef struct packed {
    logic up;
    logic down;
    logic illegal;
  } enc_step_t;

endpackage

// File: rtl/servo_bridge_ctrl.sv
module servo_bridge_ctrl
  import coil_servo_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqToMin,
  input  logic    reqToMax,
  input  logic    limMin,
  input  logic    limMax,
  output bridge_t bridge
);

  drv_state_e state, stateNext;
  logic targetMax, targetMaxNext;
  logic wantMin, wantMax;

  // Conflicting requests cancel; an end stop vetoes its own direction
  assign wantMin = reqToMin & ~reqToMax & ~limMin;
  assign wantMax = reqToMax & ~reqToMin & ~limMax;

  always_comb begin
    stateNext     = state;
    targetMaxNext = wantMax ? 1'b1 : (wantMin ? 1'b0 : targetMax);
    unique case (state)
      DRV_BRAKE: if (wantMin | wantMax) stateNext = DRV_DEAD;
      DRV_DEAD: begin
        if (wantMin && !targetMax)     stateNext = DRV_TOMIN;
        else if (wantMax && targetMax) stateNext = DRV_TOMAX;
        else if (wantMin || wantMax)   stateNext = DRV_DEAD;
        else                           stateNext = DRV_BRAKE;
      end
      DRV_TOMIN: if (!wantMin) stateNext = DRV_DEAD;
      DRV_TOMAX: if (!wantMax) stateNext = DRV_DEAD;
      default:   stateNext = DRV_BRAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= DRV_BRAKE;
      targetMax <= 1'b0;
    end else begin
      state     <= stateNext;
      targetMax <= targetMaxNext;
    end
  end

  // Limit inputs gate the drive pair combinationally for an immediate veto
  always_comb begin
    bridge = '0;
    unique case (state)
      DRV_BRAKE: begin
        bridge.loA = 1'b1;
        bridge.loB = 1'b1;
      end
      DRV_TOMIN: begin
        bridge.hiA = ~limMin;
        bridge.loB = ~limMin;
      end
      DRV_TOMAX: begin
        bridge.hiB = ~limMax;
        bridge.loA = ~limMax;
      end
      default: bridge = '0;
    endcase
  end

endmodule

// File: rtl/servo_enc_edge.sv
module servo_enc_edge
  import coil_servo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      encA,
  input  logic      encB,
  output enc_step_t step
);

  localparam int NUM_PH = 2;

  logic [NUM_PH-1:0] rawPh;
  logic [NUM_PH-1:0] curPh;
  logic [NUM_PH-1:0] prevPh;
  logic [NUM_PH-1:0] chg;
  logic              phXor;

  assign rawPh = {encA, encB};

  for (genvar g = 0; g < NUM_PH; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawPh[g]};
    end
    assign curPh[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPh <= '0;
    else       prevPh <= curPh;
  end

  // Index 1 is phase A, index 0 is phase B
  assign chg   = curPh ^ prevPh;
  assign phXor = curPh[1] ^ curPh[0];

  always_comb begin
    step         = '0;
    step.illegal = chg[1] & chg[0];
    if (chg[1] ^ chg[0]) begin
      step.up   = chg[1] ? phXor  : ~phXor;
      step.down = chg[1] ? ~phXor : phXor;
    end
  end

endmodule

// File: rtl/servo_pos_count.sv
module servo_pos_count
  import coil_servo_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  enc_step_t               step,
  output logic signed [POS_W-1:0] posCount,
  output logic                    pulse,
  output logic                    errFlag
);

  localparam logic signed [POS_W-1:0] ONE = POS_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posCount <= '0;
      pulse    <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      pulse <= step.up | step.down;
      if (step.illegal) errFlag <= 1'b1;
      if (step.up)        posCount <= posCount + ONE;
      else if (step.down) posCount <= posCount - ONE;
    end
  end

endmodule

// File: rtl/coil_servo_drive.sv
module coil_servo_drive
  import coil_servo_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqToMin,
  input  logic                    reqToMax,
  input  logic                    limMin,
  input  logic                    limMax,
  input  logic                    encA,
  input  logic                    encB,
  output logic                    hiSideA,
  output logic                    loSideA,
  output logic                    hiSideB,
  output logic                    loSideB,
  output logic                    atMin,
  output logic                    atMax,
  output logic                    motionPulse,
  output logic                    stepError,
  output logic signed [POS_W-1:0] position
);

  bridge_t   bridge;
  enc_step_t step;

  servo_bridge_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqToMin(reqToMin), .reqToMax(reqToMax),
    .limMin(limMin), .limMax(limMax),
    .bridge(bridge)
  );

  servo_enc_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .step(step)
  );

  servo_pos_count #(.POS_W(POS_W)) count_i (
    .clk(clk), .rstN(rstN), .step(step),
    .posCount(position), .pulse(motionPulse), .errFlag(stepError)
  );

  assign hiSideA = bridge.hiA;
  assign loSideA = bridge.loA;
  assign hiSideB = bridge.hiB;
  assign loSideB = bridge.loB;
  assign atMin   = limMin;
  assign atMax   = limMax;

endmodule

// File: rtl/coil_servo_drive_chk.sv
module coil_servo_drive_chk #(
  parameter int POS_W = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqToMin,
  input logic                    reqToMax,
  input logic                    limMin,
  input logic                    limMax,
  input logic                    hiSideA,
  input logic                    loSideA,
  input logic                    hiSideB,
  input logic                    loSideB,
  input logic                    motionPulse,
  input logic                    stepError,
  input logic signed [POS_W-1:0] position
);

  localparam logic signed [POS_W-1:0] ONE = POS_W'(1);

  logic noReq, conflict, allOff, braking;
  assign noReq    = !reqToMin && !reqToMax;
  assign conflict = reqToMin && reqToMax;
  assign allOff   = !hiSideA && !loSideA && !hiSideB && !loSideB;
  assign braking  = loSideA && loSideB && !hiSideA && !hiSideB;

  a_r2_leg_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hiSideA && loSideA) && !(hiSideB && loSideB) && !(hiSideA && hiSideB));

  a_r3_conflict_brakes: assert property (@(posedge clk) disable iff (!rstN)
    ($past(conflict) && $past(conflict, 2)) |-> braking);

  a_r4_idle_brakes: assert property (@(posedge clk) disable iff (!rstN)
    ($past(noReq) && $past(noReq, 2)) |-> braking);

  a_r5_dead_before_a: assert property (@(posedge clk) disable iff (!rstN)
    (hiSideA && !$past(hiSideA)) |-> $past(allOff));

  a_r5_dead_before_b: assert property (@(posedge clk) disable iff (!rstN)
    (hiSideB && !$past(hiSideB)) |-> $past(allOff));

  a_r6_veto_min: assert property (@(posedge clk) disable iff (!rstN)
    limMin |-> !hiSideA);

  a_r6_veto_max: assert property (@(posedge clk) disable iff (!rstN)
    limMax |-> !hiSideB);

  a_r8_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    (position == $past(position)) || (position == $past(position) + ONE) ||
    (position == $past(position) - ONE));

  a_r9_pulse_moves: assert property (@(posedge clk) disable iff (!rstN)
    motionPulse |-> (position != $past(position)));

  a_r9_quiet_holds: assert property (@(posedge clk) disable iff (!rstN)
    !motionPulse |-> $stable(position));

  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(stepError) |-> stepError);

endmodule

bind coil_servo_drive coil_servo_drive_chk #(.POS_W(POS_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqToMin(reqToMin), .reqToMax(reqToMax),
  .limMin(limMin), .limMax(limMax),
  .hiSideA(hiSideA), .loSideA(loSideA), .hiSideB(hiSideB), .loSideB(loSideB),
  .motionPulse(motionPulse), .stepError(stepError), .position(position)
);

// File: tb/coil_servo_drive_tb_top.sv
`timescale 1ns/1ps
module coil_servo_drive_tb_top;

  localparam int POS_W = 16;
  localparam int M_BRK = 0, M_DED = 1, M_MIN = 2, M_MAX = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rMin = 0, rMax = 0, lMin = 0, lMax = 0, eA = 0, eB = 0;
  logic hiA, loA, hiB, loB, atMin, atMax, pulse, err;
  logic signed [POS_W-1:0] pos;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  // bench model state
  int mSt = M_BRK;
  bit mTgtMax = 0;
  bit mA1 = 0, mB1 = 0, mA2 = 0, mB2 = 0, mPA = 0, mPB = 0;
  logic signed [POS_W-1:0] mPos = '0;
  bit mPulse = 0, mErr = 0;
  int phase = 0;

  always #2.5 clk = ~clk;

  coil_servo_drive #(.POS_W(POS_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqToMin(rMin), .reqToMax(rMax),
    .limMin(lMin), .limMax(lMax), .encA(eA), .encB(eB),
    .hiSideA(hiA), .loSideA(loA), .hiSideB(hiB), .loSideB(loB),
    .atMin(atMin), .atMax(atMax), .motionPulse(pulse),
    .stepError(err), .position(pos)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setPhase(input int p);
    phase = p & 3;
    eA = (phase == 1) || (phase == 2);
    eB = (phase == 2) || (phase == 3);
  endtask

  // Expected behaviour from the requirements, advanced once per clock edge
  task automatic modelEdge();
    bit wMin, wMax, cA, cB, x;
    wMin = rMin && !rMax && !lMin;
    wMax = rMax && !rMin && !lMax;
    case (mSt)
      M_BRK: if (wMin || wMax) mSt = M_DED;
      M_DED: begin
        if (wMin && !mTgtMax) mSt = M_MIN;
        else if (wMax && mTgtMax) mSt = M_MAX;
        else if (!(wMin || wMax)) mSt = M_BRK;
      end
      M_MIN: if (!wMin) mSt = M_DED;
      default: if (!wMax) mSt = M_DED;
    endcase
    if (wMax) mTgtMax = 1; else if (wMin) mTgtMax = 0;
    cA = mA2 ^ mPA; cB = mB2 ^ mPB; x = mA2 ^ mB2;
    mPulse = 0;
    if (cA && cB) mErr = 1;
    else if (cA || cB) begin
      mPulse = 1;
      if (cA ? x : !x) mPos = mPos + 1; else mPos = mPos - 1;
    end
    mPA = mA2; mPB = mB2; mA2 = mA1; mB2 = mB1; mA1 = eA; mB1 = eB;
  endtask

  task automatic checkAll();
    bit xHiA, xLoA, xHiB, xLoB;
    string tag;
    xHiA = (mSt == M_MIN) && !lMin;
    xLoB = ((mSt == M_MIN) && !lMin) || (mSt == M_BRK);
    xHiB = (mSt == M_MAX) && !lMax;
    xLoA = ((mSt == M_MAX) && !lMax) || (mSt == M_BRK);
    if (mSt == M_BRK) tag = "R4 brake";
    else if (mSt == M_DED) tag = "R5 dead";
    else if ((mSt == M_MIN && lMin) || (mSt == M_MAX && lMax)) tag = "R6 veto";
    else tag = "R2 drive";
    chk({hiA, loA, hiB, loB} == {xHiA, xLoA, xHiB, xLoB}, tag,
        {hiA, loA, hiB, loB}, {xHiA, xLoA, xHiB, xLoB});
    chk(atMin == lMin && atMax == lMax, "R6 status", {atMin, atMax}, {lMin, lMax});
    chk(pos == mPos, "R8 position", pos, mPos);
    chk(pulse == mPulse, "R9 pulse", pulse, mPulse);
    chk(err == mErr, "R10 error", err, mErr);
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    #1;
    checkAll();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk({hiA, loA, hiB, loB} == 4'b0101, "R1 bridge", {hiA, loA, hiB, loB}, 4'b0101);
    chk(pos == 0 && !pulse && !err, "R1 counters", pos, 0);
    rstN = 1'b1;
    tick();
    chk({hiA, loA, hiB, loB} == 4'b0101, "R1 after release", {hiA, loA, hiB, loB}, 4'b0101);

    // R7: latency of the encoder path
    setPhase(1);
    tick(); tick();
    chk(pos == 0 && !pulse, "R7 early", pos, 0);
    tick();
    chk(pos == 1 && pulse, "R7 third edge", pos, 1);
    tick();
    chk(!pulse, "R9 single cycle", pulse, 0);

    // R5 then R2 toward minimum, then release
    rMin = 1;
    tick();
    chk({hiA, loA, hiB, loB} == 4'b0000, "R5 dead on entry", {hiA, loA, hiB, loB}, 0);
    tick();
    chk({hiA, loA, hiB, loB} == 4'b1001, "R2 to min", {hiA, loA, hiB, loB}, 4'b1001);
    // R6: veto takes effect without a clock edge
    lMin = 1; #1;
    checkAll();
    chk(!hiA && !loB && atMin, "R6 immediate veto", {hiA, loB, atMin}, 3'b001);
    tick();
    lMin = 0; rMin = 0;
    tick(); tick();
    chk({hiA, loA, hiB, loB} == 4'b0101, "R4 settles", {hiA, loA, hiB, loB}, 4'b0101);

    // R2 toward maximum, then R3 conflict
    rMax = 1;
    tick(); tick();
    chk({hiA, loA, hiB, loB} == 4'b0110, "R2 to max", {hiA, loA, hiB, loB}, 4'b0110);
    rMin = 1;
    tick(); tick(); tick();
    chk({hiA, loA, hiB, loB} == 4'b0101, "R3 conflict brakes", {hiA, loA, hiB, loB}, 4'b0101);
    rMin = 0; rMax = 0;

    // R8: walk backward through zero to test wrap
    for (int i = 0; i < 3; i++) begin
      setPhase(phase - 1);
      tick();
    end
    repeat (3) tick();
    chk(pos == -2 && pos[POS_W-1], "R8 wrap below zero", pos, -2);

    // Random stretch
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) begin
        rMin = $urandom_range(2) == 0;
        rMax = $urandom_range(2) == 0;
      end
      if ($urandom_range(15) == 0) begin
        lMin = $urandom_range(3) == 0;
        lMax = $urandom_range(3) == 0;
      end
      case ($urandom_range(5))
        0: setPhase(phase + 1);
        1: setPhase(phase - 1);
        default: ;
      endcase
      tick();
    end

    // R10: double phase change
    rMin = 0; rMax = 0; lMin = 0; lMax = 0;
    repeat (4) tick();
    begin
      logic signed [POS_W-1:0] held;
      held = pos;
      setPhase(phase + 2);
      repeat (3) tick();
      chk(err && pos == held && !pulse, "R10 illegal step", pos, held);
      repeat (5) tick();
      chk(err, "R10 sticky", err, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule